// File: doc/BRIEF.md
# Set-Aside Partitioned Cache Replacement Controller

This block holds the tags and the replacement state of a set-associative cache in which some of the ways in every set can be reserved for lines that should stay resident. Each lookup carries an address, a write flag and a property code that marks it as streaming, normal or persisting. One cycle later the block reports whether the lookup hit, which way it hit or which way was picked as the victim, and whether that victim must be written back first. The line is installed in the same cycle, so the data array outside the block can use the reported way at once.

Each line has a valid bit, a dirty bit, a class (streaming, normal or persisting), a recency rank within its set and an idle-age counter. Control inputs set how many low ways form the reserved region, turn the region off, demote every persisting line at once, and supply a periodic tick that ages lines. Persisting lines that go untouched for long enough lose their status by themselves.

Top module: `persist_way_ctrl`

## Requirements
- R1: A lookup with `req_valid` high gives `resp_valid` high on the next cycle, with `resp_hit` high exactly when a valid line of the indexed set holds the request tag. Address bits [3:0] are the line offset, [7:4] the set, [15:8] the tag.
- R2: On a miss, the lowest-numbered invalid way among the eligible ways is chosen before any valid line.
- R3: With no eligible invalid way, the victim is the least recently used streaming line, else the least recently used normal line, else the least recently used persisting line. Property codes: 2'b00 normal, 2'b01 streaming, 2'b10 persisting, 2'b11 treated as normal.
- R4: The reserved region is the lowest K ways, K = min(`setaside_ways`, MAX_SETASIDE). A persisting miss with K > 0 fills only a way below K and the line becomes persisting; with K = 0 a persisting lookup behaves as normal.
- R5: A streaming or normal miss never evicts a persisting line held in a reserved way, but may fill a reserved way that holds no persisting line.
- R6: When all reserved ways hold persisting lines, a persisting miss evicts the least recently used of them.
- R7: A normal-property hit on a persisting line makes it a normal line that competes for eviction like any other.
- R8: A `persist_clear` pulse turns every persisting line into a normal line in that cycle.
- R9: Every tick of `age_tick` raises the idle age of each valid line up to 15; an access clears it. A persisting line whose age reaches 15 becomes normal; after 14 ticks it is still persisting.
- R10: With `setaside_off` high, K is 0: no line becomes persisting and all ways are shared equally.
- R11: `resp_writeback` is high only on a miss whose victim was valid and dirty; a write access marks the line dirty and a read fill leaves it clean.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 16 | Lookup byte address |
| req_prop | input | 2 | Property code of the lookup |
| req_write | input | 1 | Lookup is a write |
| setaside_ways | input | 2 | Requested number of reserved ways |
| setaside_off | input | 1 | Disable the reserved region |
| persist_clear | input | 1 | Demote all persisting lines |
| age_tick | input | 1 | Aging tick |
| resp_valid | output | 1 | Response valid |
| resp_hit | output | 1 | Lookup hit |
| resp_way | output | 2 | Hit way or victim way |
| resp_writeback | output | 1 | Victim is dirty and must be written back |

## Verification
The bench uses the default geometry of four ways and sixteen sets with a cap of three reserved ways, so a single set can be filled, overfilled and reordered in a handful of lookups, and every class priority becomes visible in a single victim choice. The small set count lets each scenario take a fresh set, so bulk demotion, aging and disabling are each judged on lines that no earlier scenario touched. The four-bit age counter keeps the revert point at fifteen ticks, so both sides of that bound are exercised.

// File: rtl/persist_way_ctrl.sv
module persist_way_ctrl #(
  parameter int WAYS         = 4,
  parameter int SETS         = 16,
  parameter int ADDR_W       = 16,
  parameter int LINE_W       = 4,
  parameter int MAX_SETASIDE = 3,
  parameter int AGE_W        = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [1:0]              req_prop,
  input  logic                    req_write,
  input  logic [$clog2(WAYS)-1:0] setaside_ways,
  input  logic                    setaside_off,
  input  logic                    persist_clear,
  input  logic                    age_tick,
  output logic                    resp_valid,
  output logic                    resp_hit,
  output logic [$clog2(WAYS)-1:0] resp_way,
  output logic                    resp_writeback
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - LINE_W;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;
  localparam logic [1:0] C_NRM = 2'b00, C_STR = 2'b01, C_PER = 2'b10;

  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [1:0]       cls_q  [SETS][WAYS];
  logic [WAY_W-1:0] rank_q [SETS][WAYS];
  logic [AGE_W-1:0] age_q  [SETS][WAYS];
  logic [WAYS-1:0]  vld_q  [SETS];
  logic [WAYS-1:0]  dirty_q[SETS];

  wire [IDX_W-1:0] idx = req_addr[LINE_W +: IDX_W];
  wire [TAG_W-1:0] tag = req_addr[ADDR_W-1 -: TAG_W];

  wire [WAY_W-1:0] k_eff = setaside_off ? '0 :
                           (setaside_ways > WAY_W'(MAX_SETASIDE)) ? WAY_W'(MAX_SETASIDE) : setaside_ways;
  wire pers_req = (req_prop == C_PER) && (k_eff != '0);

  logic [WAYS-1:0]    hit_vec, elig;
  logic [WAY_W-1:0]   hit_way, victim, acc_way, acc_rank;
  logic [WAY_W+1:0]   key, best;
  logic               found;
  logic [1:0]         lvl, new_cls;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = vld_q[idx][w] && (tag_q[idx][w] == tag);
      if (hit_vec[w]) hit_way = WAY_W'(w);
      elig[w] = pers_req ? (WAY_W'(w) < k_eff)
                         : !((WAY_W'(w) < k_eff) && vld_q[idx][w] && cls_q[idx][w] == C_PER);
    end
  end

  always_comb begin
    victim = '0;
    best   = '1;
    found  = 1'b0;
    key    = '0;
    lvl    = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!vld_q[idx][w])              lvl = 2'd0;
      else if (cls_q[idx][w] == C_STR) lvl = 2'd1;
      else if (cls_q[idx][w] == C_PER) lvl = 2'd3;
      else                             lvl = 2'd2;
      key = {lvl, (lvl == 2'd0) ? {WAY_W{1'b0}} : ~rank_q[idx][w]};
      if (elig[w] && (!found || key < best)) begin
        found  = 1'b1;
        best   = key;
        victim = WAY_W'(w);
      end
    end
  end

  wire hit = |hit_vec;
  assign acc_way  = hit ? hit_way : victim;
  assign acc_rank = rank_q[idx][acc_way];

  always_comb begin
    if (hit) begin
      if (pers_req && acc_way < k_eff)                new_cls = C_PER;
      else if (req_prop == C_NRM || req_prop == 2'b11) new_cls = C_NRM;
      else                                             new_cls = cls_q[idx][acc_way];
    end else begin
      if (pers_req)                new_cls = C_PER;
      else if (req_prop == C_STR)  new_cls = C_STR;
      else                         new_cls = C_NRM;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]   <= '0;
        dirty_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w]  <= '0;
          cls_q[s][w]  <= C_NRM;
          rank_q[s][w] <= WAY_W'(w);
          age_q[s][w]  <= '0;
        end
      end
      resp_valid     <= 1'b0;
      resp_hit       <= 1'b0;
      resp_way       <= '0;
      resp_writeback <= 1'b0;
    end else begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          if (persist_clear && cls_q[s][w] == C_PER) cls_q[s][w] <= C_NRM;
          if (age_tick && vld_q[s][w] && age_q[s][w] != AGE_MAX) begin
            age_q[s][w] <= age_q[s][w] + 1'b1;
            if (age_q[s][w] == AGE_MAX - 1'b1 && cls_q[s][w] == C_PER) cls_q[s][w] <= C_NRM;
          end
        end
      if (req_valid) begin
        for (int w = 0; w < WAYS; w++)
          if (rank_q[idx][w] < acc_rank) rank_q[idx][w] <= rank_q[idx][w] + 1'b1;
        rank_q[idx][acc_way]  <= '0;
        vld_q[idx][acc_way]   <= 1'b1;
        tag_q[idx][acc_way]   <= tag;
        cls_q[idx][acc_way]   <= new_cls;
        age_q[idx][acc_way]   <= '0;
        dirty_q[idx][acc_way] <= req_write || (hit && dirty_q[idx][acc_way]);
      end
      resp_valid     <= req_valid;
      resp_hit       <= req_valid && hit;
      resp_way       <= acc_way;
      resp_writeback <= req_valid && !hit && vld_q[idx][victim] && dirty_q[idx][victim];
    end
  end

  a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);
  a_r11_wb_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    resp_writeback |-> resp_valid && !resp_hit);
  a_r2_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit && |(elig & ~vld_q[idx])) |-> !vld_q[idx][victim]);
  a_r4_fill_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit && pers_req) |=> resp_way < $past(k_eff));
  a_r5_keep_persist: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit && !pers_req) |->
      !(victim < k_eff && vld_q[idx][victim] && cls_q[idx][victim] == C_PER));
endmodule

// File: tb/persist_way_ctrl_test.sv
module persist_way_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_prop = '0;
  logic        req_write = 1'b0;
  logic [1:0]  setaside_ways = 2'd2;
  logic        setaside_off = 1'b0;
  logic        persist_clear = 1'b0;
  logic        age_tick = 1'b0;
  logic        resp_valid, resp_hit, resp_writeback;
  logic [1:0]  resp_way;

  localparam logic [1:0] NRM = 2'b00, STR = 2'b01, PER = 2'b10;

  persist_way_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_prop(req_prop), .req_write(req_write), .setaside_ways(setaside_ways),
    .setaside_off(setaside_off), .persist_clear(persist_clear), .age_tick(age_tick),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
    .resp_writeback(resp_writeback)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic       hit;
    logic [1:0] way;
    logic       wb;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, expv);
    end
  endtask

  task automatic lookup(input logic [7:0] t, input logic [3:0] set, input logic [1:0] prop,
                        input logic wr, input logic eh, input logic [1:0] ew,
                        input logic ewb, input string name);
    exp_t e;
    @(negedge clk);
    e.hit = eh; e.way = ew; e.wb = ewb; e.tag = name;
    exp_q.push_back(e);
    req_valid = 1'b1;
    req_addr  = {t, set, 4'h0};
    req_prop  = prop;
    req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); age_tick = 1'b1;
      @(negedge clk); age_tick = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected response", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(resp_hit == e.hit, {e.tag, " hit"}, resp_hit, e.hit);
        if (!e.hit || resp_hit) chk(resp_way == e.way, {e.tag, " way"}, resp_way, e.way);
        chk(resp_writeback == e.wb, {e.tag, " writeback"}, resp_writeback, e.wb);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(resp_valid == 1'b0, "R1 reset resp_valid", resp_valid, 0);
    chk(resp_hit == 1'b0, "R1 reset resp_hit", resp_hit, 0);
    chk(resp_writeback == 1'b0, "R11 reset resp_writeback", resp_writeback, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // set 0, K = 2
    lookup(8'h01, 4'd0, PER, 0, 0, 2'd0, 0, "R4 persist fill in region");
    lookup(8'h02, 4'd0, NRM, 0, 0, 2'd1, 0, "R5 normal uses free reserved way");
    lookup(8'h03, 4'd0, STR, 1, 0, 2'd2, 0, "R2 invalid way first");
    lookup(8'h04, 4'd0, NRM, 0, 0, 2'd3, 0, "R2 last invalid way");
    lookup(8'h01, 4'd0, PER, 0, 1, 2'd0, 0, "R1 hit on filled line");
    lookup(8'h05, 4'd0, NRM, 0, 0, 2'd2, 1, "R3 R11 streaming dirty victim");
    lookup(8'h06, 4'd0, NRM, 0, 0, 2'd1, 0, "R3 LRU normal victim");
    lookup(8'h07, 4'd0, PER, 0, 0, 2'd1, 0, "R4 persist evicts normal in region");
    lookup(8'h08, 4'd0, PER, 0, 0, 2'd0, 0, "R6 LRU persisting evicted");
    lookup(8'h04, 4'd0, NRM, 0, 1, 2'd3, 0, "R1 hit way3");
    lookup(8'h05, 4'd0, NRM, 0, 1, 2'd2, 0, "R1 hit way2");
    lookup(8'h09, 4'd0, NRM, 0, 0, 2'd3, 0, "R5 persisting LRU line kept");
    lookup(8'h07, 4'd0, NRM, 0, 1, 2'd1, 0, "R7 normal hit on persisting");
    lookup(8'h09, 4'd0, NRM, 0, 1, 2'd3, 0, "R7 touch way3");
    lookup(8'h05, 4'd0, NRM, 0, 1, 2'd2, 0, "R7 touch way2");
    lookup(8'h0A, 4'd0, NRM, 0, 0, 2'd1, 0, "R7 demoted line evicted");

    // set 1: bulk clear
    lookup(8'h11, 4'd1, PER, 0, 0, 2'd0, 0, "R8 fill p0");
    lookup(8'h12, 4'd1, PER, 0, 0, 2'd1, 0, "R8 fill p1");
    lookup(8'h13, 4'd1, NRM, 0, 0, 2'd2, 0, "R8 fill n2");
    lookup(8'h14, 4'd1, NRM, 0, 0, 2'd3, 0, "R8 fill n3");
    @(negedge clk); persist_clear = 1'b1;
    @(negedge clk); persist_clear = 1'b0;
    lookup(8'h15, 4'd1, NRM, 0, 0, 2'd0, 0, "R8 cleared line evicted");

    // set 2: aging
    lookup(8'h21, 4'd2, PER, 0, 0, 2'd0, 0, "R9 fill p0");
    lookup(8'h22, 4'd2, NRM, 0, 0, 2'd1, 0, "R9 fill n1");
    lookup(8'h23, 4'd2, NRM, 0, 0, 2'd2, 0, "R9 fill n2");
    lookup(8'h24, 4'd2, NRM, 0, 0, 2'd3, 0, "R9 fill n3");
    pulse_tick(14);
    lookup(8'h25, 4'd2, NRM, 0, 0, 2'd1, 0, "R9 still persisting after 14 ticks");
    pulse_tick(1);
    lookup(8'h26, 4'd2, NRM, 0, 0, 2'd0, 0, "R9 reverted after 15 ticks");

    // set 3: disabled region
    setaside_off = 1'b1;
    lookup(8'h31, 4'd3, PER, 0, 0, 2'd0, 0, "R10 fill 0");
    lookup(8'h32, 4'd3, PER, 0, 0, 2'd1, 0, "R10 fill 1");
    lookup(8'h33, 4'd3, PER, 0, 0, 2'd2, 0, "R10 fill 2");
    lookup(8'h34, 4'd3, PER, 0, 0, 2'd3, 0, "R10 fill 3");
    lookup(8'h35, 4'd3, NRM, 0, 0, 2'd0, 0, "R10 shared ways");
    setaside_off = 1'b0;

    // set 4: K = 0
    setaside_ways = 2'd0;
    lookup(8'h41, 4'd4, PER, 1, 0, 2'd0, 0, "R4 K0 fill 0");
    lookup(8'h42, 4'd4, PER, 0, 0, 2'd1, 0, "R4 K0 fill 1");
    lookup(8'h43, 4'd4, PER, 0, 0, 2'd2, 0, "R4 K0 fill 2");
    lookup(8'h44, 4'd4, PER, 0, 0, 2'd3, 0, "R4 K0 fill 3");
    lookup(8'h45, 4'd4, NRM, 0, 0, 2'd0, 1, "R4 R11 K0 persist acts normal");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R1 responses outstanding", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule